// File: doc/BRIEF.md
# DMA Channel Descriptor Decoder

This block sits at the front of one DMA channel. It accepts one 16-byte channel descriptor at a time and turns it into a single dispatch action: no-op, stop, output transfer, input transfer, load word, store word or kill. It checks the key field and the buffer address of data-moving commands. For the two word commands it turns the request count into a byte size of 1, 2 or 4 and aligns the address down to that size. It also runs the single memory access that each word command needs. A store writes a right-shifted copy of the descriptor's dependency word. A load merges the bytes it reads into the top of that word and hands the updated word back.

Descriptors come in on a valid/ready handshake. The decoder takes a descriptor only while `desc_ready` is high, and `desc_ready` stays low from the acceptance of a word command until its memory access has finished. A store finishes at the request handshake. A load finishes when its response arrives. The action, and the pulses that tell the channel's status logic which bits to change, appear as one-cycle pulses in the cycle after acceptance. The memory request side is also valid/ready. A request holds all of its fields stable until `mem_req_ready` is seen. Responses have no back-pressure.

Descriptor layout on `desc_word` (bit ranges): [15:0] request count, [31:16] command, [63:32] address, [95:64] dependency word, [111:96] residual count, [127:112] transfer status. The last two fields are carried but not decoded.

Top module: `dbd_decoder`

## Requirements
- R1: When `desc_valid` and `desc_ready` are both high at a rising edge, `act_valid` is high for exactly the following cycle. `act_valid` is never high without such an acceptance.
- R2: The opcode is command bits [15:12] (0 output-more, 1 output-last, 2 input-more, 3 input-last, 4 store word, 5 load word, 6 no-op, 7 stop). `act_code` reports 0 no-op, 1 stop, 2 output, 3 input, 4 load, 5 store, 6 kill. Opcodes 8 to 15 kill the channel.
- R3: An output or input command kills the channel if its key (command bits [10:8]) is above 3, which includes the illegal key 4, or if its address is zero.
- R4: A legal output or input command reports the descriptor address on `act_addr` and the 16-bit request count on `act_count`. `act_last` is set for the two "last" opcodes. For no-op, stop and kill, `act_last`, `act_addr` and `act_count` are zero.
- R5: For load and store, only request count bits [2:0] matter. Bit 2 set gives size 4 with the address aligned down to a multiple of 4. Otherwise bit 1 set gives size 2 with the address aligned down to a multiple of 2. Otherwise the size is 1 with the address unchanged. The size appears on `act_count` and `mem_req_size`, and the aligned address appears on `act_addr` and `mem_req_addr`.
- R6: A load or store whose key is not 6 kills the channel and issues no memory request.
- R7: A load of size 4 returns the read word on `dep_word`. Size 2 returns {read[15:0], dep[15:0]}. Size 1 returns {read[7:0], dep[23:0]}. `dep_valid` pulses in the cycle after the response.
- R8: A store issues a write whose data is the dependency word shifted right by 0, 16 or 24 bits for size 4, 2 or 1.
- R9: A kill pulses `st_set_dead`, `st_clr_active` and `irq_raise` together with the action, and leaves `st_clr_dead` and `st_clr_flush` low.
- R10: A stop pulses `st_clr_active`, `st_clr_dead` and `st_clr_flush`, raises no interrupt and makes no memory request.
- R11: A memory request is presented in the cycle after acceptance and keeps its fields stable until `mem_req_ready`. `desc_ready` stays low until a store's request handshake or a load's response.
- R12: After reset, `desc_ready` is high and `act_valid`, `mem_req_valid`, `dep_valid` and `irq_raise` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Decoder can take a descriptor |
| desc_word | input | 128 | Packed 16-byte descriptor |
| act_valid | output | 1 | Action pulse |
| act_code | output | 3 | Decoded action |
| act_last | output | 1 | Transfer is the last of its packet |
| act_addr | output | 32 | Transfer or aligned word address |
| act_count | output | 16 | Transfer count or word size |
| st_set_dead | output | 1 | Status update: set dead |
| st_clr_active | output | 1 | Status update: clear active |
| st_clr_dead | output | 1 | Status update: clear dead |
| st_clr_flush | output | 1 | Status update: clear flush |
| irq_raise | output | 1 | Interrupt request pulse |
| mem_req_valid | output | 1 | Word access request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_addr | output | 32 | Aligned byte address |
| mem_req_size | output | 3 | Byte count 1, 2 or 4 |
| mem_req_wdata | output | 32 | Store data, right-justified |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_rdata | input | 32 | Load data, right-justified |
| dep_valid | output | 1 | Merged dependency word valid |
| dep_word | output | 32 | Merged dependency word |

## Verification
The bench targets request counts in which several size bits are set at once. A design with the wrong priority would pick the wrong size and alignment, for example treating a count of 7 as 1 byte. It also sends transfers with a zero address or key 4, which a faulty decoder would let through as real transfers. Loads of each size check that the low bytes of the dependency word survive the merge and are not overwritten. Memory stalls of random length check that a request does not drop or change its fields, and that no second descriptor is taken while a word access is still open.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 4;
  localparam int KEY_W   = 3;
  localparam int SIZE_W  = 3;
  localparam int DESC_W  = 4 * CNT_W + ADDR_W + WORD_W;
  localparam int F_REQ   = 0;
  localparam int F_CMD   = CNT_W;
  localparam int F_ADDR  = 2 * CNT_W;
  localparam int F_DEP   = 2 * CNT_W + ADDR_W;
  localparam int F_TAIL  = F_DEP + WORD_W;

  localparam logic [OPC_W-1:0] OPC_OUT_MORE = 4'd0;
  localparam logic [OPC_W-1:0] OPC_OUT_LAST = 4'd1;
  localparam logic [OPC_W-1:0] OPC_IN_MORE  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_IN_LAST  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_STORE    = 4'd4;
  localparam logic [OPC_W-1:0] OPC_LOAD     = 4'd5;
  localparam logic [OPC_W-1:0] OPC_NOP      = 4'd6;
  localparam logic [OPC_W-1:0] OPC_STOP     = 4'd7;

  localparam logic [KEY_W-1:0] KEY_ILLEGAL  = 3'd4;

  typedef enum logic [2:0] {
    ACT_NOP   = 3'd0,
    ACT_STOP  = 3'd1,
    ACT_OUT   = 3'd2,
    ACT_IN    = 3'd3,
    ACT_LOAD  = 3'd4,
    ACT_STORE = 3'd5,
    ACT_KILL  = 3'd6
  } act_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_RSP  = 2'd2
  } seq_e;

  typedef struct packed {
    act_e              code;
    logic              last;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  count;
    logic              mem_op;
    logic              mem_wr;
    logic [SIZE_W-1:0] size;
  } dec_t;
endpackage

// File: rtl/dbd_size_norm.sv
module dbd_size_norm
  import dbd_pkg::*;
(
  input  logic [2:0]        req_lo,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] addr_al
);
  always_comb begin
    if (req_lo[2]) begin
      size    = 3'd4;
      addr_al = {addr_in[ADDR_W-1:2], 2'b00};
    end else if (req_lo[1]) begin
      size    = 3'd2;
      addr_al = {addr_in[ADDR_W-1:1], 1'b0};
    end else begin
      size    = 3'd1;
      addr_al = addr_in;
    end
  end
  logic unused_req0;
  assign unused_req0 = req_lo[0];
endmodule

// File: rtl/dbd_field_decode.sv
module dbd_field_decode
  import dbd_pkg::*;
#(
  parameter int MAX_STREAM_KEY = 3,
  parameter int SYS_KEY        = 6
) (
  input  logic [F_TAIL-1:0] desc,
  output dec_t              dec,
  output logic              kill,
  output logic              stop
);
  localparam logic [KEY_W-1:0] MAX_KEY = KEY_W'(MAX_STREAM_KEY);
  localparam logic [KEY_W-1:0] SYSK    = KEY_W'(SYS_KEY);

  logic [CNT_W-1:0]  req;
  logic [CNT_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [OPC_W-1:0]  opc;
  logic [KEY_W-1:0]  key;
  logic [SIZE_W-1:0] w_size;
  logic [ADDR_W-1:0] w_addr;
  logic              bad_xfer;

  assign req  = desc[F_REQ  +: CNT_W];
  assign cmd  = desc[F_CMD  +: CNT_W];
  assign addr = desc[F_ADDR +: ADDR_W];
  assign opc  = cmd[15:12];
  assign key  = cmd[10:8];

  logic unused_cmd;
  assign unused_cmd = ^{cmd[11], cmd[7:0], desc[F_DEP +: WORD_W]};

  dbd_size_norm u_size (
    .req_lo  (req[2:0]),
    .addr_in (addr),
    .size    (w_size),
    .addr_al (w_addr)
  );

  assign bad_xfer = (key > MAX_KEY) || (key == KEY_ILLEGAL) || (addr == '0);

  always_comb begin
    dec      = '0;
    dec.code = ACT_KILL;
    case (opc)
      OPC_NOP:  dec.code = ACT_NOP;
      OPC_STOP: dec.code = ACT_STOP;
      OPC_OUT_MORE, OPC_OUT_LAST, OPC_IN_MORE, OPC_IN_LAST: begin
        if (!bad_xfer) begin
          dec.code  = opc[1] ? ACT_IN : ACT_OUT;
          dec.last  = opc[0];
          dec.addr  = addr;
          dec.count = req;
        end
      end
      OPC_STORE, OPC_LOAD: begin
        if (key == SYSK && key != KEY_ILLEGAL) begin
          dec.code   = (opc == OPC_LOAD) ? ACT_LOAD : ACT_STORE;
          dec.addr   = w_addr;
          dec.count  = CNT_W'(w_size);
          dec.mem_op = 1'b1;
          dec.mem_wr = (opc == OPC_STORE);
          dec.size   = w_size;
        end
      end
      default: dec.code = ACT_KILL;
    endcase
  end

  assign kill = (dec.code == ACT_KILL);
  assign stop = (dec.code == ACT_STOP);
endmodule

// File: rtl/dbd_store_shift.sv
module dbd_store_shift
  import dbd_pkg::*;
(
  input  logic [WORD_W-1:0] dep,
  input  logic [SIZE_W-1:0] size,
  output logic [WORD_W-1:0] wdata
);
  always_comb begin
    case (size)
      3'd2:    wdata = dep >> 16;
      3'd1:    wdata = dep >> 24;
      default: wdata = dep;
    endcase
  end
endmodule

// File: rtl/dbd_load_merge.sv
module dbd_load_merge
  import dbd_pkg::*;
(
  input  logic [WORD_W-1:0] dep,
  input  logic [WORD_W-1:0] rdata,
  input  logic [SIZE_W-1:0] size,
  output logic [WORD_W-1:0] merged
);
  always_comb begin
    case (size)
      3'd2:    merged = {rdata[15:0], dep[15:0]};
      3'd1:    merged = {rdata[7:0], dep[23:0]};
      default: merged = rdata;
    endcase
  end
endmodule

// File: rtl/dbd_mem_seq.sv
module dbd_mem_seq
  import dbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_write,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic idle,
  output logic req_valid,
  output logic load_done
);
  seq_e state;
  logic write_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      write_q <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state   <= SQ_REQ;
          write_q <= start_write;
        end
        SQ_REQ:  if (req_ready) state <= write_q ? SQ_IDLE : SQ_RSP;
        SQ_RSP:  if (rsp_valid) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (state == SQ_IDLE);
  assign req_valid = (state == SQ_REQ);
  assign load_done = (state == SQ_RSP) && rsp_valid;
endmodule

// File: rtl/dbd_decoder.sv
module dbd_decoder
  import dbd_pkg::*;
#(
  parameter int MAX_STREAM_KEY = 3,
  parameter int SYS_KEY        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [DESC_W-1:0] desc_word,
  output logic              act_valid,
  output logic [2:0]        act_code,
  output logic              act_last,
  output logic [ADDR_W-1:0] act_addr,
  output logic [CNT_W-1:0]  act_count,
  output logic              st_set_dead,
  output logic              st_clr_active,
  output logic              st_clr_dead,
  output logic              st_clr_flush,
  output logic              irq_raise,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SIZE_W-1:0] mem_req_size,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              dep_valid,
  output logic [WORD_W-1:0] dep_word
);
  dec_t              dec;
  logic              kill, stop;
  logic              accept;
  logic              seq_idle, load_done;
  logic [WORD_W-1:0] st_data, merged;
  logic [WORD_W-1:0] dep_q;

  logic unused_tail;
  assign unused_tail = ^desc_word[DESC_W-1:F_TAIL];

  dbd_field_decode #(
    .MAX_STREAM_KEY (MAX_STREAM_KEY),
    .SYS_KEY        (SYS_KEY)
  ) u_dec (
    .desc (desc_word[F_TAIL-1:0]),
    .dec  (dec),
    .kill (kill),
    .stop (stop)
  );

  dbd_store_shift u_shift (
    .dep   (desc_word[F_DEP +: WORD_W]),
    .size  (dec.size),
    .wdata (st_data)
  );

  dbd_load_merge u_merge (
    .dep    (dep_q),
    .rdata  (mem_rsp_rdata),
    .size   (mem_req_size),
    .merged (merged)
  );

  dbd_mem_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept && dec.mem_op),
    .start_write (dec.mem_wr),
    .req_ready   (mem_req_ready),
    .rsp_valid   (mem_rsp_valid),
    .idle        (seq_idle),
    .req_valid   (mem_req_valid),
    .load_done   (load_done)
  );

  assign desc_ready = seq_idle;
  assign accept     = desc_valid && desc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid     <= 1'b0;
      act_code      <= '0;
      act_last      <= 1'b0;
      act_addr      <= '0;
      act_count     <= '0;
      st_set_dead   <= 1'b0;
      st_clr_active <= 1'b0;
      st_clr_dead   <= 1'b0;
      st_clr_flush  <= 1'b0;
      irq_raise     <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_size  <= '0;
      mem_req_wdata <= '0;
      dep_q         <= '0;
      dep_valid     <= 1'b0;
      dep_word      <= '0;
    end else begin
      act_valid     <= accept;
      st_set_dead   <= accept && kill;
      st_clr_active <= accept && (kill || stop);
      st_clr_dead   <= accept && stop;
      st_clr_flush  <= accept && stop;
      irq_raise     <= accept && kill;
      dep_valid     <= load_done;
      if (accept) begin
        act_code  <= dec.code;
        act_last  <= dec.last;
        act_addr  <= dec.addr;
        act_count <= dec.count;
      end
      if (accept && dec.mem_op) begin
        mem_req_write <= dec.mem_wr;
        mem_req_addr  <= dec.addr;
        mem_req_size  <= dec.size;
        mem_req_wdata <= dec.mem_wr ? st_data : '0;
        dep_q         <= desc_word[F_DEP +: WORD_W];
      end
      if (load_done) dep_word <= merged;
    end
  end
endmodule

// File: rtl/dbd_decoder_chk.sv
module dbd_decoder_chk
  import dbd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              act_valid,
  input logic [2:0]        act_code,
  input logic              st_set_dead,
  input logic              st_clr_active,
  input logic              st_clr_flush,
  input logic              irq_raise,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [SIZE_W-1:0] mem_req_size,
  input logic [WORD_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              dep_valid
);
  AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> act_valid); // R1
  AST_ACT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(desc_valid && desc_ready)); // R1
  AST_KILL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == 3'd6) |-> (st_set_dead && st_clr_active && irq_raise)); // R9
  AST_KILL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == 3'd6) |-> !mem_req_valid); // R6
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == 3'd1) |-> (!mem_req_valid && !irq_raise && st_clr_flush)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_size) && $stable(mem_req_wdata))); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !desc_ready); // R11
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_size) == 1)); // R5
  AST_ALIGN4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_size == 3'd4) |-> (mem_req_addr[1:0] == 2'b00)); // R5
  AST_DEP_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    dep_valid |-> $past(mem_rsp_valid)); // R7
endmodule

bind dbd_decoder dbd_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .desc_valid    (desc_valid),
  .desc_ready    (desc_ready),
  .act_valid     (act_valid),
  .act_code      (act_code),
  .st_set_dead   (st_set_dead),
  .st_clr_active (st_clr_active),
  .st_clr_flush  (st_clr_flush),
  .irq_raise     (irq_raise),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .dep_valid     (dep_valid)
);

// File: tb/dbd_decoder_tb_top.sv
module dbd_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         desc_valid = 1'b0;
  logic         desc_ready;
  logic [127:0] desc_word = '0;
  logic         act_valid;
  logic [2:0]   act_code;
  logic         act_last;
  logic [31:0]  act_addr;
  logic [15:0]  act_count;
  logic         st_set_dead, st_clr_active, st_clr_dead, st_clr_flush, irq_raise;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [2:0]   mem_req_size;
  logic [31:0]  mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [31:0]  mem_rsp_rdata = '0;
  logic         dep_valid;
  logic [31:0]  dep_word;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dbd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_word(desc_word), .act_valid(act_valid), .act_code(act_code),
    .act_last(act_last), .act_addr(act_addr), .act_count(act_count),
    .st_set_dead(st_set_dead), .st_clr_active(st_clr_active),
    .st_clr_dead(st_clr_dead), .st_clr_flush(st_clr_flush), .irq_raise(irq_raise),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .dep_valid(dep_valid), .dep_word(dep_word)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected decode from the requirements
  function automatic void model(input logic [127:0] d, output logic [2:0] code,
      output logic last, output logic [31:0] addr, output logic [15:0] cnt,
      output logic [4:0] st, output logic mem, output logic wr, output logic [2:0] sz,
      output logic [31:0] wd);
    logic [15:0] rq = d[15:0];
    logic [3:0]  op = d[31:28];
    logic [2:0]  ky = d[26:24];
    logic [31:0] ad = d[63:32];
    logic [31:0] dp = d[95:64];
    code = 3'd6; last = 0; addr = 0; cnt = 0; mem = 0; wr = 0; sz = 0; wd = 0;
    if (op == 4'd6) code = 3'd0;
    else if (op == 4'd7) code = 3'd1;
    else if (op <= 4'd3) begin
      if (ky <= 3'd3 && ad != 0) begin
        code = (op >= 4'd2) ? 3'd3 : 3'd2;
        last = (op == 4'd1 || op == 4'd3);
        addr = ad; cnt = rq;
      end
    end else if (op == 4'd4 || op == 4'd5) begin
      if (ky == 3'd6) begin
        code = (op == 4'd5) ? 3'd4 : 3'd5;
        mem = 1; wr = (op == 4'd4);
        if (rq[2]) begin sz = 4; addr = ad & 32'hFFFF_FFFC; end
        else if (rq[1]) begin sz = 2; addr = ad & 32'hFFFF_FFFE; end
        else begin sz = 1; addr = ad; end
        cnt = {13'd0, sz};
        if (wr) wd = (sz == 4) ? dp : (sz == 2) ? {16'd0, dp[31:16]} : {24'd0, dp[31:24]};
      end
    end
    // {set_dead, clr_active, clr_dead, clr_flush, irq}
    st = (code == 3'd6) ? 5'b11001 : (code == 3'd1) ? 5'b01110 : 5'b00000;
  endfunction

  function automatic logic [31:0] merge_exp(input logic [31:0] dp, input logic [31:0] rd,
                                            input logic [2:0] sz);
    if (sz == 4) return rd;
    if (sz == 2) return {rd[15:0], dp[15:0]};
    return {rd[7:0], dp[23:0]};
  endfunction

  task automatic run_desc(input logic [127:0] d);
    logic [2:0] code; logic last; logic [31:0] addr; logic [15:0] cnt;
    logic [4:0] st; logic mem; logic wr; logic [2:0] sz; logic [31:0] wd;
    model(d, code, last, addr, cnt, st, mem, wr, sz, wd);
    @(negedge clk);
    chk("R1 ready before offer", desc_ready, 1);
    desc_word = d; desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R1 act_valid after accept", act_valid, 1);
    chk("R2 R3 R6 act_code", act_code, code);
    chk("R4 R5 last/addr/count", {act_last, act_addr, act_count}, {last, addr, cnt});
    chk("R9 R10 status pulses",
        {st_set_dead, st_clr_active, st_clr_dead, st_clr_flush, irq_raise}, st);
    chk("R6 R10 mem_req_valid", mem_req_valid, mem);
    if (mem) begin
      chk("R5 request fields", {mem_req_write, mem_req_addr, mem_req_size}, {wr, addr, sz});
      if (wr) chk("R8 store data", mem_req_wdata, wd);
      for (int k = 0; k < 1 + int'($urandom % 3); k++) begin
        @(negedge clk);
        chk("R1 action is one pulse", act_valid, 0);
        chk("R11 request held", {mem_req_valid, mem_req_addr, mem_req_size, desc_ready},
            {1'b1, addr, sz, 1'b0});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R11 request dropped after handshake", mem_req_valid, 0);
      if (!wr) begin
        logic [31:0] rd;
        chk("R11 busy until response", desc_ready, 0);
        for (int j = 0; j < int'($urandom % 3); j++) @(negedge clk);
        rd = $urandom;
        mem_rsp_rdata = rd; mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk("R7 dep_valid", dep_valid, 1);
        chk("R7 merged word", dep_word, merge_exp(d[95:64], rd, sz));
      end
      chk("R11 ready after access", desc_ready, 1);
    end else begin
      @(negedge clk);
      chk("R1 action is one pulse", act_valid, 0);
      chk("R10 no request", mem_req_valid, 0);
    end
  endtask

  function automatic logic [127:0] mk(input logic [3:0] op, input logic [2:0] ky,
      input logic [31:0] ad, input logic [15:0] rq, input logic [31:0] dp);
    return {32'h0, dp, ad, op, 1'b0, ky, 8'h00, rq};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset state", {desc_ready, act_valid, mem_req_valid, dep_valid, irq_raise},
        5'b10000);
    // Directed corner cases
    run_desc(mk(4'd1, 3'd2, 32'h0000_1000, 16'h0040, 32'h0));        // R4 output last
    run_desc(mk(4'd2, 3'd0, 32'h0, 16'h0010, 32'h0));                // R3 zero address
    run_desc(mk(4'd0, 3'd4, 32'h0000_2000, 16'h0010, 32'h0));        // R3 key 4
    run_desc(mk(4'd5, 3'd6, 32'h0000_1237, 16'h0007, 32'hAABBCCDD)); // R5 size 4
    run_desc(mk(4'd5, 3'd6, 32'h0000_1237, 16'h0003, 32'hAABBCCDD)); // R5 R7 size 2
    run_desc(mk(4'd5, 3'd6, 32'h0000_1237, 16'h0008, 32'hAABBCCDD)); // R5 R7 size 1
    run_desc(mk(4'd4, 3'd6, 32'h0000_3003, 16'h0002, 32'h12345678)); // R8 store 2
    run_desc(mk(4'd4, 3'd6, 32'h0000_3003, 16'h0001, 32'h12345678)); // R8 store 1
    run_desc(mk(4'd4, 3'd5, 32'h0000_3000, 16'h0004, 32'h1));        // R6 bad key
    run_desc(mk(4'd7, 3'd0, 32'h0, 16'h0, 32'h0));                   // R10 stop
    run_desc(mk(4'd6, 3'd0, 32'h0, 16'h0, 32'h0));                   // R2 no-op
    run_desc(mk(4'd9, 3'd6, 32'h0000_4000, 16'h0004, 32'h0));        // R2 R9 reserved
    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op; logic [2:0] ky; logic [31:0] ad;
      int r = int'($urandom % 10);
      op = (r < 8) ? 4'(r) : 4'(8 + $urandom % 8);
      if ($urandom % 2 == 0) ky = (op == 4'd4 || op == 4'd5) ? 3'd6 : 3'($urandom % 4);
      else ky = 3'($urandom);
      ad = ($urandom % 8 == 0) ? 32'h0 : $urandom;
      d = mk(op, ky, ad, 16'($urandom), $urandom);
      d[127:112] = 16'($urandom);
      d[111:96]  = 16'($urandom);
      run_desc(d);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule